// File: doc/BRIEF.md
# Supply Supervisor Event Mask Controller

This block is the digital control wrapped around a pair of supply-supervisor comparators, a low-side one (index 0) and a high-side one (index 1). It decides when each comparator is powered. That decision uses a per-side enable register, the core's low-power state and a per-side "stay on in sleep" bit. Every time a comparator is switched on, the block ignores that comparator's output for a settling window. The window length depends on whether the side runs in full-performance or in normal mode.

Once a comparator has settled, a synchronized fault indication sets a sticky per-side fault flag. A flag on a side whose reset-enable bit is set asserts a power-on-reset request. While any flag is set on a side whose comparator is not settled, a pin-isolation output asks the pad ring to float all general-purpose pins. The comparators, the reset generator and the pads lie outside the block and appear only as plain inputs and outputs.

The low-power state is encoded as 0 = run, 1..4 = low-power states 1 to 4. States 2, 3 and 4 are the deep states. `rst_n` is asynchronous and active low, and it is expected to be released synchronously to `clk` by the reset tree. `soft_rst` is a one-cycle software-reset pulse.

Top module: `svmask_ctrl`

## Requirements
- R1: `cmp_on[i]` is 1 exactly when enable bit i is 1, except when `lpm_state` is 2, 3 or 4 and `keep_on[i]` is 0; in that case it is 0.
- R2: The enable register holds 1 in every bit after `rst_n` is released and after a `soft_rst` pulse, even if software had cleared bits before. Otherwise it loads `en_wdata` on a cycle with `en_wr` = 1.
- R3: Every switch-on of a comparator starts a settling window in which its fault input cannot set the flag. Switch-on events are reset release, a soft reset, an enable write and a wake from a deep state. With the fault input already high, the flag first reads 1 after L+2 rising edges, counted from the edge that ends the cycle in which `lpm_state` returns to run or `rst_n` is released. The count is L+3 edges from the edge that ends the cycle of an `en_wr` or `soft_rst` pulse. L is `FP_SETTLE_CYC` if `fp_sel[i]` was 1 at the switch-on and `NM_SETTLE_CYC` otherwise.
- R4: Changing `fp_sel[i]` while a window runs does not change that window's length; it only affects later switch-on events.
- R5: With `keep_on[i]` = 1, entering and leaving a deep state starts no settling window.
- R6: Each fault input passes through a two-flop synchronizer. On a settled comparator, a fault that rises before an edge sets the flag on the third edge.
- R7: A fault flag stays set until a `flag_clr[i]` strobe; a strobe in a cycle where a qualified fault is also present leaves the flag set.
- R8: `por_req` is 1 whenever some side has both its flag and its `rst_en` bit set, in the same cycle, and 0 otherwise.
- R9: `pin_hiz` is 1 whenever some side has its flag set and its comparator is off or still inside its settling window, and 0 otherwise.
- R10: A side whose comparator is switched off never sets its flag, whatever its fault input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lpm_state | input | 3 | Low-power state, 0 run, 1..4 low-power states |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | N_SIDES | Enable register write value |
| fp_sel | input | N_SIDES | Per-side full-performance select |
| keep_on | input | N_SIDES | Per-side keep-comparator-on-in-deep-sleep bit |
| rst_en | input | N_SIDES | Per-side reset-request enable |
| flag_clr | input | N_SIDES | Per-side fault flag clear strobe |
| soft_rst | input | 1 | Software reset pulse, re-enables both comparators |
| cmp_raw | input | N_SIDES | Asynchronous comparator fault outputs, 1 = fault |
| cmp_on | output | N_SIDES | Comparator power enables |
| fault_flag | output | N_SIDES | Sticky fault flags |
| por_req | output | 1 | Power-on-reset request |
| pin_hiz | output | 1 | Float all general-purpose pins |

## Verification
For each side, the main timing check measures how many edges pass between a switch-on event and the first flag. The sweep covers every combination of full-performance select, keep-on bit and low-power state 1 to 4. A count of 3 shows that no window was started, and a count of L+2 shows a window of the expected mode. This tells a deep state apart from state 1, a kept-on comparator apart from a gated one, and the full-performance length apart from the normal one. Separate patterns cover the other switch-on sources. An enable write and a soft reset after a software disable each give L+3. A mode change in mid-window keeps the original length. The flag, clear, reset-request and pin-isolation outputs are checked at exact cycles around a sleep and wake.

// File: rtl/svmask_pkg.sv
package svmask_pkg;

  localparam int unsigned LPM_W = 3;

  typedef enum logic [LPM_W-1:0] {
    PWR_RUN = 3'd0,
    PWR_LP1 = 3'd1,
    PWR_LP2 = 3'd2,
    PWR_LP3 = 3'd3,
    PWR_LP4 = 3'd4
  } pwr_state_e;

  // Deep states gate comparators that are not kept on.
  function automatic logic lpm_is_deep(input logic [LPM_W-1:0] st);
    return (st == PWR_LP2) || (st == PWR_LP3) || (st == PWR_LP4);
  endfunction

endpackage

// File: rtl/svmask_sync2.sv
module svmask_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/svmask_settle.sv
module svmask_settle #(
  parameter int unsigned FP_CYC = 48,
  parameter int unsigned NM_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic comp_on,
  input  logic restart,
  input  logic fp_mode,
  output logic settled
);

  localparam int unsigned MAX_CYC = (FP_CYC > NM_CYC) ? FP_CYC : NM_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] FP_LOAD = CNT_W'(FP_CYC - 1);
  localparam logic [CNT_W-1:0] NM_LOAD = CNT_W'(NM_CYC - 1);

  logic             on_q, on_n;
  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             start_w;

  // A switch-on is seen as a rising edge of the gated enable.
  assign start_w = comp_on & ~on_q;

  always_comb begin
    on_n   = on_q;
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (!comp_on || restart) begin
      on_n   = 1'b0;
      busy_n = 1'b0;
      cnt_n  = '0;
    end else if (start_w) begin
      // Length is fixed here; later mode changes wait for the next start.
      on_n   = 1'b1;
      busy_n = 1'b1;
      cnt_n  = fp_mode ? FP_LOAD : NM_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      on_q   <= on_n;
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign settled = on_q & ~busy_q;

endmodule

// File: rtl/svmask_side.sv
module svmask_side #(
  parameter int unsigned FP_CYC = 48,
  parameter int unsigned NM_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_bit,
  input  logic deep,
  input  logic keep_on,
  input  logic fp_mode,
  input  logic restart,
  input  logic rst_en,
  input  logic clr,
  input  logic raw,
  output logic cmp_on,
  output logic flag,
  output logic settled,
  output logic por_bit,
  output logic hiz_bit
);

  logic raw_s;
  logic flag_q, flag_n;
  logic fault_seen;

  assign cmp_on = en_bit & ~(deep & ~keep_on);

  svmask_sync2 #(.W(1)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (raw_s)
  );

  svmask_settle #(.FP_CYC(FP_CYC), .NM_CYC(NM_CYC)) settle_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .comp_on (cmp_on),
    .restart (restart),
    .fp_mode (fp_mode),
    .settled (settled)
  );

  assign fault_seen = raw_s & settled;

  // New fault wins over a clear in the same cycle.
  always_comb begin
    flag_n = (flag_q & ~clr) | fault_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_n;
    end
  end

  assign flag    = flag_q;
  assign por_bit = flag_q & rst_en;
  assign hiz_bit = flag_q & ~settled;

endmodule

// File: rtl/svmask_ctrl.sv
module svmask_ctrl
  import svmask_pkg::*;
#(
  parameter int unsigned N_SIDES       = 2,
  parameter int unsigned FP_SETTLE_CYC = 48,
  parameter int unsigned NM_SETTLE_CYC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LPM_W-1:0]   lpm_state,
  input  logic               en_wr,
  input  logic [N_SIDES-1:0] en_wdata,
  input  logic [N_SIDES-1:0] fp_sel,
  input  logic [N_SIDES-1:0] keep_on,
  input  logic [N_SIDES-1:0] rst_en,
  input  logic [N_SIDES-1:0] flag_clr,
  input  logic               soft_rst,
  input  logic [N_SIDES-1:0] cmp_raw,
  output logic [N_SIDES-1:0] cmp_on,
  output logic [N_SIDES-1:0] fault_flag,
  output logic               por_req,
  output logic               pin_hiz
);

  logic [N_SIDES-1:0] en_q, en_n;
  logic [N_SIDES-1:0] side_settled;
  logic [N_SIDES-1:0] side_por;
  logic [N_SIDES-1:0] side_hiz;
  logic               deep_w;

  assign deep_w = lpm_is_deep(lpm_state);

  // Enable register: every reset source turns both sides back on.
  always_comb begin
    en_n = en_q;
    if (soft_rst) begin
      en_n = '1;
    end else if (en_wr) begin
      en_n = en_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '1;
    end else begin
      en_q <= en_n;
    end
  end

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    svmask_side #(.FP_CYC(FP_SETTLE_CYC), .NM_CYC(NM_SETTLE_CYC)) side_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_bit  (en_q[g]),
      .deep    (deep_w),
      .keep_on (keep_on[g]),
      .fp_mode (fp_sel[g]),
      .restart (soft_rst),
      .rst_en  (rst_en[g]),
      .clr     (flag_clr[g]),
      .raw     (cmp_raw[g]),
      .cmp_on  (cmp_on[g]),
      .flag    (fault_flag[g]),
      .settled (side_settled[g]),
      .por_bit (side_por[g]),
      .hiz_bit (side_hiz[g])
    );
  end

  assign por_req = |side_por;
  assign pin_hiz = |side_hiz;

endmodule

// File: rtl/svmask_ctrl_chk.sv
module svmask_ctrl_chk
  import svmask_pkg::*;
#(
  parameter int unsigned N_SIDES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [LPM_W-1:0]   lpm_state,
  input logic [N_SIDES-1:0] keep_on,
  input logic               soft_rst,
  input logic [N_SIDES-1:0] flag_clr,
  input logic [N_SIDES-1:0] cmp_on,
  input logic [N_SIDES-1:0] fault_flag,
  input logic               pin_hiz,
  input logic [N_SIDES-1:0] settled
);

  logic [N_SIDES-1:0] off_mask;
  assign off_mask = lpm_is_deep(lpm_state) ? ~keep_on : '0;

  // R1
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_on & off_mask) == '0);

  // R2
  soft_reen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> ((cmp_on | off_mask) == '1));

  // R3
  flag_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_flag & ~$past(fault_flag)) & ~$past(settled)) == '0);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(fault_flag) & ~fault_flag) & ~$past(flag_clr)) == '0);

  // R9
  hiz_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_hiz |-> (fault_flag != '0));

endmodule

bind svmask_ctrl svmask_ctrl_chk #(.N_SIDES(N_SIDES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .lpm_state  (lpm_state),
  .keep_on    (keep_on),
  .soft_rst   (soft_rst),
  .flag_clr   (flag_clr),
  .cmp_on     (cmp_on),
  .fault_flag (fault_flag),
  .pin_hiz    (pin_hiz),
  .settled    (side_settled)
);

// File: tb/svmask_ctrl_tb_top.sv
`timescale 1ns/1ps
module svmask_ctrl_tb_top;

  localparam int FP = 12;
  localparam int NM = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] lpm_state;
  logic       en_wr;
  logic [1:0] en_wdata;
  logic [1:0] fp_sel;
  logic [1:0] keep_on;
  logic [1:0] rst_en;
  logic [1:0] flag_clr;
  logic       soft_rst;
  logic [1:0] cmp_raw;
  logic [1:0] cmp_on;
  logic [1:0] fault_flag;
  logic       por_req;
  logic       pin_hiz;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  svmask_ctrl #(.N_SIDES(2), .FP_SETTLE_CYC(FP), .NM_SETTLE_CYC(NM)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lpm_state  (lpm_state),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .fp_sel     (fp_sel),
    .keep_on    (keep_on),
    .rst_en     (rst_en),
    .flag_clr   (flag_clr),
    .soft_rst   (soft_rst),
    .cmp_raw    (cmp_raw),
    .cmp_on     (cmp_on),
    .fault_flag (fault_flag),
    .por_req    (por_req),
    .pin_hiz    (pin_hiz)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts rising edges until the side's flag reads 1; drops pulses after the first edge.
  task automatic measure(input int s, input int exp, input string req);
    int  cnt  = 0;
    bit  seen = 1'b0;
    while (!seen && cnt < 400) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      en_wr    = 1'b0;
      soft_rst = 1'b0;
      flag_clr = '0;
      if (fault_flag[s]) seen = 1'b1;
    end
    chk(req, cnt, exp);
  endtask

  task automatic prep();
    cmp_raw = '0;
    repeat (4) @(negedge clk);
    flag_clr = '1;
    @(negedge clk);
    flag_clr = '0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    n_vec++;
    $display("FAIL watchdog: actual 0 expected 1");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    lpm_state = 3'd0;
    en_wr     = 1'b0;
    en_wdata  = '0;
    fp_sel    = '0;
    keep_on   = '0;
    rst_en    = '0;
    flag_clr  = '0;
    soft_rst  = 1'b0;
    cmp_raw   = 2'b11;
    repeat (3) @(negedge clk);

    // Reset state
    chk("R2 reset enables", cmp_on, 3);
    chk("R7 reset flags", fault_flag, 0);
    chk("R8 reset por", por_req, 0);
    chk("R9 reset hiz", pin_hiz, 0);

    // R3: window after reset release, fault already present
    rst_n = 1'b1;
    measure(0, NM + 2, "R3 reset release window");
    chk("R3 reset release side1", fault_flag[1], 1);

    // R8
    rst_en = 2'b01;
    #1 chk("R8 por with rst_en", por_req, 1);
    rst_en = 2'b00;
    #1 chk("R8 por masked", por_req, 0);
    chk("R9 hiz settled", pin_hiz, 0);
    @(negedge clk);

    // R7: clear together with a live fault keeps the flag
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = '0;
    chk("R7 clear vs fault", fault_flag[0], 1);
    prep();
    chk("R7 clear after fault gone", fault_flag, 0);

    // Sweep: side, mode, keep-on, low-power state (R1, R3, R5, R6)
    for (int s = 0; s < 2; s++) begin
      for (int fp = 0; fp < 2; fp++) begin
        for (int ko = 0; ko < 2; ko++) begin
          for (int lp = 1; lp <= 4; lp++) begin
            int  len;
            bit  gated;
            prep();
            fp_sel[s]  = fp[0];
            keep_on[s] = ko[0];
            @(negedge clk);
            lpm_state = 3'(lp);
            repeat (3) @(negedge clk);
            gated = (lp >= 2) && (ko == 0);
            chk("R1 sleep gating", cmp_on[s], gated ? 0 : 1);
            len = (fp != 0) ? FP : NM;
            lpm_state  = 3'd0;
            cmp_raw[s] = 1'b1;
            if (gated) measure(s, len + 2, "R3 wake window");
            else if (ko != 0) measure(s, 3, "R5 kept on no window");
            else measure(s, 3, "R6 sync latency light sleep");
          end
        end
      end
    end
    fp_sel  = '0;
    keep_on = '0;

    // R9: flag set, comparator gated, then settling after wake
    prep();
    cmp_raw[0] = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 flag before sleep", fault_flag[0], 1);
    cmp_raw[0] = 1'b0;
    lpm_state  = 3'd3;
    @(negedge clk);
    chk("R9 hiz while gated", pin_hiz, 1);
    lpm_state = 3'd0;
    @(negedge clk);
    chk("R9 hiz window start", pin_hiz, 1);
    repeat (NM - 1) @(negedge clk);
    chk("R9 hiz window end", pin_hiz, 1);
    @(negedge clk);
    chk("R9 hiz after settle", pin_hiz, 0);

    // R4: mode change mid-window keeps the normal length
    prep();
    lpm_state = 3'd4;
    repeat (3) @(negedge clk);
    lpm_state  = 3'd0;
    cmp_raw[0] = 1'b1;
    @(negedge clk);
    fp_sel = 2'b01;
    measure(0, NM + 1, "R4 latched window");
    prep();
    // next wake uses full-performance length
    lpm_state = 3'd2;
    repeat (3) @(negedge clk);
    lpm_state  = 3'd0;
    cmp_raw[0] = 1'b1;
    measure(0, FP + 2, "R4 new mode on next wake");
    fp_sel = '0;

    // R2, R10: software disable, ignored fault, re-enable by write
    prep();
    en_wr    = 1'b1;
    en_wdata = 2'b10;
    @(negedge clk);
    en_wr = 1'b0;
    chk("R2 disable write", cmp_on, 2);
    cmp_raw[0] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 disabled fault ignored", fault_flag[0], 0);
    chk("R10 hiz stays low", pin_hiz, 0);
    en_wr    = 1'b1;
    en_wdata = 2'b11;
    measure(0, NM + 3, "R3 enable write window");

    // R2, R3: soft reset after software disable
    prep();
    en_wr    = 1'b1;
    en_wdata = 2'b10;
    @(negedge clk);
    en_wr      = 1'b0;
    cmp_raw[0] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 disabled before soft reset", fault_flag[0], 0);
    soft_rst = 1'b1;
    measure(0, NM + 3, "R3 soft reset window");
    chk("R2 soft reset reenables", cmp_on, 3);

    // R3: soft reset on an enabled side in full-performance mode
    prep();
    fp_sel     = 2'b10;
    soft_rst   = 1'b1;
    cmp_raw[1] = 1'b1;
    measure(1, FP + 3, "R3 soft reset fp window");
    rst_en = 2'b10;
    #1 chk("R8 por high side", por_req, 1);
    rst_en = '0;
    fp_sel = '0;
    prep();

    finish_run();
  end

endmodule